// File: doc/BRIEF.md
# If-Then Conditional Block Sequencer

This controller sits beside an instruction issue stage and tracks a short conditional-execution window. When a start strobe arrives, it captures a 4-bit base condition, a block length and a then/else letter vector. For each instruction issued inside the window it supplies that instruction's condition code. It also checks the code against the current N, Z, C and V flags and reports whether the instruction should execute or be suppressed.

The window covers between one and `MAX_SLOTS` instructions. The first slot always uses the base condition. Each later slot uses either the base condition or its inverse, as its letter selects. A flush, for example on a taken branch or an exception, closes the window at once. A start that arrives while a window is already open is refused and flagged. All pins are plain control and status signals. There is no data stream, so no valid/ready handshake is involved. The flag inputs are sampled combinationally, so `exec_o` follows them in the same cycle.

Top module: `it_block_seq`

## Requirements
- R1: During and straight after reset, `in_block_o` is 0, `exec_o` is 1, `nest_err_o` is 0 and `slot_cond_o` is 4'hE.
- R2: A start (`it_start_i`=1) on a clock edge where no window is open and `flush_i`=0 opens a window. From the next cycle on, `in_block_o` is 1 and `slot_cond_o` equals the captured `it_cond_i`.
- R3: Slot k (k≥2) takes its letter from `it_mask_i[k-2]`. A 1 (Then) selects the base code unchanged. A 0 (Else) selects the base code with bit 0 inverted.
- R4: A window holds `it_len_m1_i`+1 slots. Each `issue_i` edge inside the window moves to the next slot, and the issue edge on the last slot closes the window.
- R5: Inside a window, `exec_o` is the evaluation of `slot_cond_o` against `flags_i` = {N,Z,C,V} (bit 3 = N). The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R6: Codes 14 and 15 always give `exec_o`=1.
- R7: Outside a window, `exec_o` is 1, `in_block_o` is 0 and `slot_cond_o` is 4'hE, whatever the flags are.
- R8: `flush_i` on an edge closes any window by the next cycle. It takes priority over issue and start, so a start in the same cycle opens nothing.
- R9: A start on an edge where a window is open leaves the window unchanged, and `nest_err_o` is 1 for exactly the following cycle.
- R10: `issue_i` while no window is open changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| it_start_i | input | 1 | Start strobe for a new window |
| it_cond_i | input | 4 | Base condition code |
| it_len_m1_i | input | LEN_W (2) | Window length minus one |
| it_mask_i | input | MAX_SLOTS-1 (3) | Then(1)/Else(0) letters for slots 2 and up |
| issue_i | input | 1 | One instruction issued this cycle |
| flush_i | input | 1 | Close the window immediately |
| flags_i | input | 4 | {N,Z,C,V} |
| in_block_o | output | 1 | A window is open |
| slot_cond_o | output | 4 | Condition of the current slot, 4'hE when idle |
| exec_o | output | 1 | 1 = execute, 0 = suppress |
| nest_err_o | output | 1 | One-cycle pulse after a refused start |

## Verification
The bench builds the block with the default `MAX_SLOTS`=4, so that `LEN_W`=2 and `it_mask_i` is 3 bits wide. With that setting, every legal length from one to four slots and every then/else combination in the longest window can be reached. Each of the sixteen condition codes is held open in a one-slot window while all sixteen flag patterns are swept. The bench also drives starts, flushes and issues into the same cycle, including a refused start on the edge where the final slot retires.

// File: rtl/it_seq_pkg.sv
package it_seq_pkg;
  typedef logic [3:0] cond_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam cond_t COND_IDLE = 4'hE;
endpackage

// File: rtl/it_cond_eval.sv
module it_cond_eval
  import it_seq_pkg::*;
(
  input  cond_t  cond_i,
  input  flags_t flags_i,
  output logic   pass_o
);
  logic raw;

  // Even codes give the base test; an odd code inverts it, except code 15.
  always_comb begin
    unique case (cond_i[3:1])
      3'd0: raw = flags_i.z;
      3'd1: raw = flags_i.c;
      3'd2: raw = flags_i.n;
      3'd3: raw = flags_i.v;
      3'd4: raw = flags_i.c & ~flags_i.z;
      3'd5: raw = (flags_i.n == flags_i.v);
      3'd6: raw = ~flags_i.z & (flags_i.n == flags_i.v);
      default: raw = 1'b1;
    endcase
  end

  assign pass_o = (cond_i[3:1] == 3'd7) ? 1'b1 : (raw ^ cond_i[0]);
endmodule

// File: rtl/it_slot_seq.sv
module it_slot_seq
  import it_seq_pkg::*;
#(
  parameter int MAX_SLOTS = 4,
  localparam int LEN_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int PAT_W = (MAX_SLOTS > 1) ? MAX_SLOTS - 1 : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  cond_t            base_i,
  input  logic [LEN_W-1:0] len_m1_i,
  input  logic [PAT_W-1:0] mask_i,
  input  logic             issue_i,
  input  logic             flush_i,
  output logic             active_o,
  output cond_t            cond_o,
  output logic             err_o
);
  logic                 active_q;
  logic [LEN_W-1:0]     left_q;
  logic [2:0]           hi_q;
  logic [MAX_SLOTS-1:0] lsb_q;
  logic [MAX_SLOTS-1:0] lsb_load;
  logic                 err_q;

  // Bit 0 of each slot's code: the first slot keeps the base; later ones follow their letter.
  assign lsb_load[0] = base_i[0];
  for (genvar k = 1; k < MAX_SLOTS; k++) begin : g_slot
    assign lsb_load[k] = base_i[0] ^ ~mask_i[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
      hi_q     <= '0;
      lsb_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= start_i & active_q;
      if (flush_i) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        if (issue_i) begin
          lsb_q <= lsb_q >> 1;
          if (left_q == '0) active_q <= 1'b0;
          else              left_q   <= left_q - 1'b1;
        end
      end else if (start_i) begin
        active_q <= 1'b1;
        left_q   <= len_m1_i;
        hi_q     <= base_i[3:1];
        lsb_q    <= lsb_load;
      end
    end
  end

  assign active_o = active_q;
  assign cond_o   = active_q ? {hi_q, lsb_q[0]} : COND_IDLE;
  assign err_o    = err_q;
endmodule

// File: rtl/it_block_seq.sv
module it_block_seq
  import it_seq_pkg::*;
#(
  parameter int MAX_SLOTS = 4,
  localparam int LEN_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int PAT_W = (MAX_SLOTS > 1) ? MAX_SLOTS - 1 : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             it_start_i,
  input  logic [3:0]       it_cond_i,
  input  logic [LEN_W-1:0] it_len_m1_i,
  input  logic [PAT_W-1:0] it_mask_i,
  input  logic             issue_i,
  input  logic             flush_i,
  input  logic [3:0]       flags_i,
  output logic             in_block_o,
  output logic [3:0]       slot_cond_o,
  output logic             exec_o,
  output logic             nest_err_o
);
  cond_t cur_cond;
  logic  active;
  logic  pass;

  it_slot_seq #(.MAX_SLOTS(MAX_SLOTS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (it_start_i),
    .base_i   (it_cond_i),
    .len_m1_i (it_len_m1_i),
    .mask_i   (it_mask_i),
    .issue_i  (issue_i),
    .flush_i  (flush_i),
    .active_o (active),
    .cond_o   (cur_cond),
    .err_o    (nest_err_o)
  );

  it_cond_eval u_eval (
    .cond_i  (cur_cond),
    .flags_i (flags_t'(flags_i)),
    .pass_o  (pass)
  );

  assign in_block_o  = active;
  assign slot_cond_o = cur_cond;
  assign exec_o      = active ? pass : 1'b1;
endmodule

// File: rtl/it_block_seq_chk.sv
module it_block_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       it_start_i,
  input logic [3:0] it_cond_i,
  input logic       issue_i,
  input logic       flush_i,
  input logic       in_block_o,
  input logic [3:0] slot_cond_o,
  input logic       exec_o,
  input logic       nest_err_o
);
  AST_OPEN_ON_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    it_start_i && !in_block_o && !flush_i |=> in_block_o && slot_cond_o == $past(it_cond_i)); // R2
  AST_ALWAYS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    in_block_o && slot_cond_o[3:1] == 3'b111 |-> exec_o); // R6
  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_block_o |-> exec_o && slot_cond_o == 4'hE); // R7
  AST_FLUSH_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !in_block_o); // R8
  AST_NEST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    it_start_i && in_block_o |=> nest_err_o); // R9
  AST_NEST_ERR_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    nest_err_o |-> $past(it_start_i && in_block_o)); // R9
  AST_NEST_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    it_start_i && in_block_o && !issue_i && !flush_i |=> in_block_o && $stable(slot_cond_o)); // R9
  AST_IDLE_ISSUE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_block_o && issue_i && !it_start_i |=> !in_block_o); // R10
endmodule

bind it_block_seq it_block_seq_chk u_chk (.*);

// File: tb/test_it_block_seq.sv
module test_it_block_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] base = 4'h0;
  logic [1:0] lenm1 = 2'd0;
  logic [2:0] mask = 3'd0;
  logic       issue = 1'b0;
  logic       flush = 1'b0;
  logic [3:0] flags = 4'h0;
  logic       in_block, exec_o, nest_err;
  logic [3:0] slot_cond;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] q[$];
  bit err_m = 1'b0;

  always #4 clk = ~clk;

  it_block_seq i_it_block_seq (
    .clk(clk), .rst_n(rst_n), .it_start_i(start), .it_cond_i(base),
    .it_len_m1_i(lenm1), .it_mask_i(mask), .issue_i(issue), .flush_i(flush),
    .flags_i(flags), .in_block_o(in_block), .slot_cond_o(slot_cond),
    .exec_o(exec_o), .nest_err_o(nest_err)
  );

  function automatic bit ref_eval(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk1(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string req);
    logic [3:0] ec;
    ec = (q.size() > 0) ? q[0] : 4'hE;
    chk1(req, "in_block", {3'b0, in_block}, {3'b0, q.size() > 0});
    chk1(req, "slot_cond", slot_cond, ec);
    chk1(req, "exec", {3'b0, exec_o}, {3'b0, (q.size() > 0) ? ref_eval(ec, flags) : 1'b1});
    chk1(req, "nest_err", {3'b0, nest_err}, {3'b0, err_m});
  endtask

  // Apply inputs, compare, then let one edge pass and advance the model.
  task automatic cyc(input string req, input bit s, input logic [3:0] b, input logic [1:0] l,
                     input logic [2:0] m, input bit is, input bit fl, input logic [3:0] f);
    bit busy;
    start = s; base = b; lenm1 = l; mask = m; issue = is; flush = fl; flags = f;
    #1 compare(req);
    @(posedge clk);
    busy = q.size() > 0;
    err_m = s && busy;
    if (fl) q.delete();
    else if (busy) begin
      if (is) void'(q.pop_front());
    end else if (s) begin
      q.push_back(b);
      for (int k = 1; k <= int'(l); k++) q.push_back(m[k-1] ? b : (b ^ 4'd1));
    end
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: outputs in and right after reset
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    cyc("R1", 0, 0, 0, 0, 0, 0, 4'h0);
    // R10: issue while idle, R7 flags ignored while idle
    cyc("R10", 0, 4'h3, 0, 0, 1, 0, 4'hF);
    cyc("R7", 0, 4'h0, 0, 0, 0, 0, 4'h0);
    // R2, R3, R4: four-slot window, letters T E T
    cyc("R2", 1, 4'h0, 2'd3, 3'b101, 0, 0, 4'h4);
    for (int i = 0; i < 4; i++) cyc("R3", 0, 0, 0, 0, 1, 0, 4'h4);
    cyc("R4", 0, 0, 0, 0, 0, 0, 4'h0);
    // R3: all else letters, odd base; stall cycles without issue
    cyc("R2", 1, 4'hB, 2'd3, 3'b000, 0, 0, 4'h9);
    cyc("R4", 0, 0, 0, 0, 0, 0, 4'h9);
    for (int i = 0; i < 4; i++) cyc("R3", 0, 0, 0, 0, 1, 0, 4'h1);
    // R4: lengths one to three
    for (int l = 0; l < 3; l++) begin
      cyc("R4", 1, 4'h6, 2'(l), 3'b011, 0, 0, 4'h1);
      for (int i = 0; i <= l; i++) cyc("R4", 0, 0, 0, 0, 1, 0, 4'h0);
      cyc("R4", 0, 0, 0, 0, 0, 0, 4'h0);
    end
    // R5, R6: every code against every flag pattern
    for (int c = 0; c < 16; c++) begin
      cyc("R2", 1, 4'(c), 2'd0, 3'b000, 0, 0, 4'h0);
      for (int f = 0; f < 16; f++) cyc((c >= 14) ? "R6" : "R5", 0, 0, 0, 0, 0, 0, 4'(f));
      cyc("R4", 0, 0, 0, 0, 1, 0, 4'h0);
    end
    // R8: flush mid window, flush beats issue, flush with idle start
    cyc("R8", 1, 4'h2, 2'd3, 3'b111, 0, 0, 4'h2);
    cyc("R8", 0, 0, 0, 0, 1, 0, 4'h2);
    cyc("R8", 0, 0, 0, 0, 1, 1, 4'h2);
    cyc("R8", 1, 4'h4, 2'd2, 3'b000, 0, 1, 4'h8);
    cyc("R8", 0, 0, 0, 0, 0, 0, 4'h8);
    // R9: start refused while busy, including on the retiring edge
    cyc("R9", 1, 4'hA, 2'd1, 3'b001, 0, 0, 4'h0);
    cyc("R9", 1, 4'h1, 2'd3, 3'b000, 0, 0, 4'h0);
    cyc("R9", 0, 0, 0, 0, 1, 0, 4'h0);
    cyc("R9", 1, 4'h5, 2'd3, 3'b111, 1, 0, 4'h0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 4'h0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 4'h0);
    // R9: refused start together with flush
    cyc("R9", 1, 4'h3, 2'd0, 3'b000, 0, 0, 4'h0);
    cyc("R9", 1, 4'h8, 2'd0, 3'b000, 0, 1, 4'h0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 4'h0);
    // R1: reset in the middle of a window
    cyc("R1", 1, 4'hC, 2'd3, 3'b000, 0, 0, 4'h0);
    rst_n = 1'b0;
    q.delete();
    err_m = 1'b0;
    #1 compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R1", 0, 0, 0, 0, 0, 0, 4'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule